// File: doc/BRIEF.md
# Power Mode Sequencing Controller

The controller moves a processor subsystem between five power states: full speed, half speed, CPU-halted, sleep and deep sleep. All logic runs on the undivided core clock. Its outputs are clock-enable strobes: one for the CPU, one for the peripherals and one for the bus clock. The bus strobe always runs at half the current core rate. The controller also drives a memory-retain request and a PLL enable.

Software requests a state by writing a 3-bit code to a small register port. The halted state ends when an enabled interrupt arrives. The two sleep states end on a real-time-clock alarm. After that alarm the controller waits for the PLL lock indication before it restarts the CPU clock. A PLL frequency setting written by software is not applied at once. It reaches the PLL configuration output only when the controller enters deep sleep.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the state is RUN (status 0). CPU and peripheral enables are 1, memory retain is 0, the PLL enable is 1 and the PLL configuration output equals the parameter CFG_RST.
- R2: Writing 0 (RUN), 1 (SLOW), 2 (IDLE), 3 (SLEEP) or 4 (DEEP) to address 0 in RUN or SLOW changes the state. A read of address 0 returns the new state code in bits [2:0] from the next cycle on.
- R3: A write to address 0 whose 8-bit data exceeds 4 leaves the state unchanged.
- R4: In RUN the CPU enable is high every cycle and the bus enable is high on every second cycle.
- R5: In SLOW the CPU enable is high on every second cycle and the bus enable is high on every fourth cycle.
- R6: In IDLE the CPU enable is 0, the peripheral enable is 1 and the bus enable is high every second cycle. The state returns to RUN one cycle after any bit of irq_i & irq_en_i is 1. Masked interrupts have no effect.
- R7: In SLEEP and DEEP all clock enables are 0 and memory retain is 1. The PLL enable is 0 in DEEP and 1 in SLEEP.
- R8: An rtc_alarm_i pulse in SLEEP or DEEP moves the state to WAKE (status 5). In WAKE the clock enables stay 0, memory retain stays 1 and the PLL enable is 1. The state becomes RUN one cycle after pll_lock_i is seen high.
- R9: Address 2 holds a 6-bit PLL frequency value that reads back as written. pll_cfg_o takes that value only on entry into DEEP. Address 3 reads pll_cfg_o.
- R10: Mode writes while in IDLE, SLEEP, DEEP or WAKE are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on address) |
| irq_i | input | IRQ_W | Interrupt lines |
| irq_en_i | input | IRQ_W | Interrupt enables |
| rtc_alarm_i | input | 1 | Real-time-clock alarm wake event |
| pll_lock_i | input | 1 | PLL lock indication |
| cpu_clk_en_o | output | 1 | CPU clock enable strobe |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable strobe |
| mem_retain_o | output | 1 | Memory retain / self-refresh request |
| pll_en_o | output | 1 | PLL enable |
| pll_cfg_o | output | 6 | Committed PLL frequency setting |

## Verification
A wrong state register shows up at once in the next cycle's status read. Within an eight-cycle window it also changes the number of CPU, bus and peripheral enable pulses. A lost wake path leaves the status stuck and the enables at zero for as long as the wake stimulus is applied. A lock wait that is skipped shows as status 0 while pll_lock_i is still low. A configuration that is committed early shows on pll_cfg_o before deep sleep has been entered.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    PM_RUN   = 3'd0,
    PM_SLOW  = 3'd1,
    PM_IDLE  = 3'd2,
    PM_SLEEP = 3'd3,
    PM_DEEP  = 3'd4,
    PM_WAKE  = 3'd5
  } pm_state_e;

  localparam int unsigned MODE_W   = 3;
  localparam int unsigned MODE_MAX = 4;
endpackage

// File: rtl/pwr_reg_if.sv
module pwr_reg_if
  import pwr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CFG_W   = 6,
  parameter logic [CFG_W-1:0] CFG_RST = 6'd20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  pm_state_e         state_i,
  input  logic [CFG_W-1:0]  pll_cfg_i,
  output logic              mode_req_o,
  output logic [MODE_W-1:0] mode_code_o,
  output logic [CFG_W-1:0]  cfg_o
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PCFG = ADDR_W'(3);

  logic [CFG_W-1:0] cfg_q;
  logic             unused_wbits;

  assign unused_wbits = ^wdata_i[DATA_W-1:CFG_W];

  // full data word checked so stray upper bits cannot alias a legal code
  assign mode_req_o  = we_i && (addr_i == A_MODE) && (wdata_i <= DATA_W'(MODE_MAX));
  assign mode_code_o = wdata_i[MODE_W-1:0];
  assign cfg_o       = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cfg_q <= CFG_RST;
    else if (we_i && addr_i == A_FREQ)   cfg_q <= wdata_i[CFG_W-1:0];
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:  rdata_o = DATA_W'(state_i);
      A_FREQ:  rdata_o = DATA_W'(cfg_q);
      A_PCFG:  rdata_o = DATA_W'(pll_cfg_i);
      default: rdata_o = '0;
    endcase
  end

  assert_freq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_FREQ) |=> $stable(cfg_q));
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned IRQ_W = 4,
  parameter int unsigned CFG_W = 6,
  parameter logic [CFG_W-1:0] CFG_RST = 6'd20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_req_i,
  input  logic [MODE_W-1:0] mode_code_i,
  input  logic [IRQ_W-1:0]  irq_i,
  input  logic [IRQ_W-1:0]  irq_en_i,
  input  logic              rtc_alarm_i,
  input  logic              pll_lock_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output pm_state_e         state_o,
  output logic [CFG_W-1:0]  pll_cfg_o
);
  pm_state_e        state_q, state_d;
  logic [CFG_W-1:0] pll_cfg_q;
  logic             irq_hit;

  assign irq_hit = |(irq_i & irq_en_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN, PM_SLOW: if (mode_req_i) state_d = pm_state_e'(mode_code_i);
      PM_IDLE:         if (irq_hit)     state_d = PM_RUN;
      PM_SLEEP,
      PM_DEEP:         if (rtc_alarm_i) state_d = PM_WAKE;
      PM_WAKE:         if (pll_lock_i)  state_d = PM_RUN;
      default:                          state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PM_RUN;
      pll_cfg_q <= CFG_RST;
    end else begin
      state_q <= state_d;
      // deferred frequency commit happens only on the way into deep sleep
      if (state_d == PM_DEEP && state_q != PM_DEEP) pll_cfg_q <= cfg_i;
    end
  end

  assign state_o   = state_q;
  assign pll_cfg_o = pll_cfg_q;

  assert_idle_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_IDLE && irq_hit) |=> state_q == PM_RUN);
  assert_wait_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_WAKE && !pll_lock_i) |=> state_q == PM_WAKE);
  assert_sleep_alarm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == PM_SLEEP || state_q == PM_DEEP) && rtc_alarm_i) |=> state_q == PM_WAKE);
  assert_locked_modes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_DEEP && !rtc_alarm_i) |=> state_q == PM_DEEP);
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_seq_pkg::*;
#(
  parameter int unsigned DIV_W = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pm_state_e state_i,
  output logic      cpu_clk_en_o,
  output logic      per_clk_en_o,
  output logic      bus_clk_en_o,
  output logic      mem_retain_o,
  output logic      pll_en_o
);
  localparam logic [DIV_W-1:0] DIV_ALL = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic             half_tick, quarter_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign half_tick    = div_q[0];
  assign quarter_tick = (div_q == DIV_ALL);

  always_comb begin
    cpu_clk_en_o = 1'b0;
    per_clk_en_o = 1'b0;
    bus_clk_en_o = 1'b0;
    mem_retain_o = 1'b0;
    pll_en_o     = 1'b1;
    unique case (state_i)
      PM_RUN: begin
        cpu_clk_en_o = 1'b1;
        per_clk_en_o = 1'b1;
        bus_clk_en_o = half_tick;
      end
      PM_SLOW: begin
        cpu_clk_en_o = half_tick;
        per_clk_en_o = 1'b1;
        bus_clk_en_o = quarter_tick;
      end
      PM_IDLE: begin
        per_clk_en_o = 1'b1;
        bus_clk_en_o = half_tick;
      end
      PM_SLEEP, PM_WAKE: mem_retain_o = 1'b1;
      PM_DEEP: begin
        mem_retain_o = 1'b1;
        pll_en_o     = 1'b0;
      end
      default: ;
    endcase
  end

  assert_bus_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_clk_en_o |=> !bus_clk_en_o);
  assert_slow_half_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PM_SLOW && $past(state_i) == PM_SLOW && cpu_clk_en_o)
      |-> !$past(cpu_clk_en_o));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned IRQ_W = 4,
  parameter int unsigned CFG_W = 6,
  parameter logic [CFG_W-1:0] CFG_RST = 6'd20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [IRQ_W-1:0] irq_i,
  input  logic [IRQ_W-1:0] irq_en_i,
  input  logic             rtc_alarm_i,
  input  logic             pll_lock_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             bus_clk_en_o,
  output logic             mem_retain_o,
  output logic             pll_en_o,
  output logic [CFG_W-1:0] pll_cfg_o
);
  pm_state_e         state;
  logic              mode_req;
  logic [MODE_W-1:0] mode_code;
  logic [CFG_W-1:0]  cfg;

  pwr_reg_if #(.ADDR_W(2), .DATA_W(8), .CFG_W(CFG_W), .CFG_RST(CFG_RST)) i_reg_if (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .state_i(state), .pll_cfg_i(pll_cfg_o),
    .mode_req_o(mode_req), .mode_code_o(mode_code), .cfg_o(cfg)
  );

  pwr_fsm #(.IRQ_W(IRQ_W), .CFG_W(CFG_W), .CFG_RST(CFG_RST)) i_fsm (
    .clk_i, .rst_ni,
    .mode_req_i(mode_req), .mode_code_i(mode_code),
    .irq_i, .irq_en_i, .rtc_alarm_i, .pll_lock_i,
    .cfg_i(cfg), .state_o(state), .pll_cfg_o
  );

  pwr_clk_gate #(.DIV_W(2)) i_clk_gate (
    .clk_i, .rst_ni, .state_i(state),
    .cpu_clk_en_o, .per_clk_en_o, .bus_clk_en_o, .mem_retain_o, .pll_en_o
  );

  assert_bad_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i > 8'd4) |=> $stable(state));
  assert_cfg_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pll_cfg_o) |-> state == PM_DEEP);
  assert_sleep_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PM_DEEP && $past(state) == PM_DEEP) |-> !pll_en_o && !$past(bus_clk_en_o));
endmodule

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;
  localparam int IRQ_W = 4;
  localparam logic [5:0] CFG_RST = 6'd20;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [IRQ_W-1:0] irq = 0, irq_en = 0;
  logic rtc_alarm = 0, pll_lock = 1;
  logic cpu_en, per_en, bus_en, retain, pll_en;
  logic [5:0] pll_cfg;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int cur;  // expected state code

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.IRQ_W(IRQ_W), .CFG_W(6), .CFG_RST(CFG_RST)) i_pwr_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_i(irq), .irq_en_i(irq_en), .rtc_alarm_i(rtc_alarm), .pll_lock_i(pll_lock),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .bus_clk_en_o(bus_en),
    .mem_retain_o(retain), .pll_en_o(pll_en), .pll_cfg_o(pll_cfg)
  );

  function automatic int exp_cpu8(int s);
    return s == 0 ? 8 : s == 1 ? 4 : 0;
  endfunction
  function automatic int exp_bus8(int s);
    return (s == 0 || s == 2) ? 4 : s == 1 ? 2 : 0;
  endfunction
  function automatic int exp_per8(int s);
    return s <= 2 ? 8 : 0;
  endfunction
  function automatic int exp_next(int s, int code);
    if ((s == 0 || s == 1) && code <= 4) return code;
    return s;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    reg_addr = a; #1; d = int'(reg_rdata); reg_addr = 0;
  endtask

  task automatic chk_status(input string tag);
    int v;
    rd(2'd0, v);
    chk(v, cur, tag);
  endtask

  task automatic chk_window(input string tag);
    int c = 0, b = 0, p = 0, r = 0, l = 0;
    for (int i = 0; i < 8; i++) begin
      c += int'(cpu_en); b += int'(bus_en); p += int'(per_en);
      r += int'(retain); l += int'(pll_en);
      @(negedge clk);
    end
    chk(c, exp_cpu8(cur), {tag, " cpu pulses"});
    chk(b, exp_bus8(cur), {tag, " bus pulses"});
    chk(p, exp_per8(cur), {tag, " per pulses"});
    chk(r, (cur == 3 || cur == 4) ? 8 : 0, {tag, " R7 retain"});
    chk(l, cur == 4 ? 0 : 8, {tag, " R7 pll_en"});
  endtask

  // bring the block back to RUN from whatever state it is in
  task automatic recover(input bit probe);
    int v;
    if (cur == 2) begin
      if (probe) begin
        irq = 4'b0100; irq_en = 4'b1011;
        @(negedge clk);
        chk_status("R6 masked irq ignored");
        wr(2'd0, 8'd1);
        chk_status("R10 write in IDLE ignored");
      end
      irq = 4'b0010; irq_en = 4'b0010;
      @(negedge clk);
      irq = 0; irq_en = 0;
      cur = 0;
      chk_status("R6 irq wake to RUN");
    end else if (cur == 3 || cur == 4) begin
      if (cur == 4) pll_lock = 0;
      if (probe) begin
        wr(2'd0, 8'd0);
        chk_status("R10 write in sleep ignored");
      end
      rtc_alarm = 1;
      @(negedge clk);
      rtc_alarm = 0;
      cur = 5;
      if (!pll_lock) begin
        chk_status("R8 wake state");
        repeat (3) @(negedge clk);
        chk_status("R8 waits for lock");
        chk(int'(cpu_en) + int'(per_en) + int'(bus_en), 0, "R8 clocks off in wake");
        chk(int'(pll_en), 1, "R8 pll enabled in wake");
        chk(int'(retain), 1, "R8 retain in wake");
        wr(2'd0, 8'd0);
        chk_status("R10 write in WAKE ignored");
        pll_lock = 1;
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
      cur = 0;
      chk_status("R8 back to RUN after lock");
    end
  endtask

  initial begin
    int v, code, nfreq;
    void'($urandom(32'hA5C3));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur = 0;
    // R1 reset state
    chk_status("R1 reset status");
    chk(int'(cpu_en), 1, "R1 cpu_en");
    chk(int'(per_en), 1, "R1 per_en");
    chk(int'(retain), 0, "R1 retain");
    chk(int'(pll_en), 1, "R1 pll_en");
    chk(int'(pll_cfg), int'(CFG_RST), "R1 pll_cfg");
    chk_window("R4 RUN");

    // R2/R5 directed SLOW then IDLE from SLOW
    wr(2'd0, 8'd1); cur = 1;
    chk_status("R2 enter SLOW");
    chk_window("R5 SLOW");
    wr(2'd0, 8'd2); cur = 2;
    chk_status("R2 enter IDLE from SLOW");
    chk_window("R6 IDLE");
    recover(1);

    // R3 out-of-range codes incl. upper bits that alias a legal code
    wr(2'd0, 8'd7);
    chk_status("R3 code 7 ignored");
    wr(2'd0, 8'h0B);
    chk_status("R3 code 0x0B ignored");
    chk_window("R3 RUN kept");

    // R9 frequency register and deferred commit
    nfreq = int'($urandom_range(0, 63));
    if (nfreq == int'(CFG_RST)) nfreq = 5;
    wr(2'd2, 8'(nfreq));
    rd(2'd2, v); chk(v, nfreq, "R9 freq readback");
    chk(int'(pll_cfg), int'(CFG_RST), "R9 not committed in RUN");
    wr(2'd0, 8'd3); cur = 3;
    chk(int'(pll_cfg), int'(CFG_RST), "R9 not committed in SLEEP");
    chk_window("R7 SLEEP");
    recover(1);
    wr(2'd0, 8'd4); cur = 4;
    chk(int'(pll_cfg), nfreq, "R9 committed on DEEP");
    rd(2'd3, v); chk(v, nfreq, "R9 committed readback");
    chk_window("R7 DEEP");
    recover(1);

    // random sequences
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(0, 1) == 1) begin wr(2'd0, 8'd1); cur = 1; end
      code = int'($urandom_range(0, 7));
      wr(2'd0, 8'(code));
      cur = exp_next(cur, code);
      chk_status("R2 random mode write");
      chk_window("R4 R5 R6 R7 random window");
      recover(k < 4);
      if (cur == 1) begin wr(2'd0, 8'd0); cur = 0; end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule